// File: doc/BRIEF.md
# Dual-Word Load Unit

This unit executes a load of two 32-bit words with an immediate offset. The instruction arrives in one of two 32-bit layouts: a fixed layout that carries a predicate field, or a wide compressed layout. A mode input selects the layout. The unit latches the instruction word, the base register value, the condition verdict and the endianness. In the next cycle it decodes the word and either rejects it or runs it.

A legal instruction with a passing condition forms its access address from the base, the offset and the index/add controls. If that address is 8-byte aligned, the unit issues one 64-bit read. If not, it issues two 32-bit reads, four bytes apart. It then writes both destination registers in a single cycle and can also write the updated address back to the base register.

A malformed or hazardous instruction is reported on an error strobe and has no side effects. So is an instruction that belongs to another decoder.

Top module: `dwload_unit`

## Requirements
- R1: After reset the unit is idle. `busy`, `memReqValid`, every write enable and every status strobe are 0.
- R2: Fixed layout (`wideFmt`=0). The offset is `{word[11:8],word[3:0]}`, zero-extended. The first destination is `word[15:12]` and the second is that index plus one. The base is `word[19:16]`. The offset address is base+offset when `word[23]`=1 and base-offset when it is 0. The access address is the offset address when `word[24]`=1 and the unmodified base otherwise.
- R3: Wide layout (`wideFmt`=1). The offset is `word[7:0]` shifted left by two, so it ranges from 0 to 1020. The second destination is `word[11:8]`. The base, first destination, add bit and index bit sit in the same positions as in R2.
- R4: An 8-byte-aligned access address causes one read with `memReqWide`=1. With `bigEndian`=0 the first destination receives `memRspData[31:0]` and the second receives `memRspData[63:32]`. With `bigEndian`=1 the two halves swap.
- R5: An access address that is not 8-byte aligned causes two reads with `memReqWide`=0: the first at the address and the second at the address plus 4. Each read returns its word in `memRspData[31:0]`. The first word goes to the first destination and the second word to the second destination, for either endianness.
- R6: The base register receives the offset address in the write cycle, through `wbEn`/`wbIdx`/`wbData`, when writeback is selected. In the fixed layout writeback is selected when `word[24]`=0 or `word[21]`=1. In the wide layout it is selected when `word[21]`=1.
- R7: `decodeErr` pulses for one cycle, in the cycle after acceptance, whatever `condPass` says. The word triggers it when any of the following holds:
  - its shape bits mismatch: fixed needs `[27:25]`=000, `[22]`=1, `[20]`=0, `[7:4]`=1101 and `[31:28]`≠1111; wide needs `[31:25]`=1110100, `[22]`=1 and `[20]`=1;
  - writeback is selected and the base equals either destination;
  - in the fixed layout: `word[24]`=0 with `word[21]`=1, an odd first destination, or a second destination of 15;
  - in the wide layout: either destination is 15, or the two destinations are equal.

  No read and no register write follow.
- R8: A well-shaped word whose base field is 1111 pulses `notMine` for one cycle in the cycle after acceptance, with no side effects. So does a wide word with `word[24]`=0 and `word[21]`=0.
- R9: A legal word accepted with `condPass`=0 pulses `retire` in the cycle after acceptance, with no read and no register write.
- R10: `busy` is 1 from the cycle after acceptance up to and including the write cycle. While `memReqReady` is 0, a pending request keeps its address and size.
- R11: With no stalls, the write cycle (`wrEnA`, `wrEnB` and `retire` all 1) is the 4th cycle after acceptance for an aligned access and the 6th for an unaligned one. Each cycle that `memReqReady` is held low adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| issueValid | input | 1 | Instruction offered; accepted when not busy |
| issueWord | input | 32 | Instruction word |
| wideFmt | input | 1 | 0 selects the fixed layout, 1 the wide layout |
| condPass | input | 1 | Condition verdict for this instruction |
| bigEndian | input | 1 | Word order of an aligned 64-bit read |
| baseIdx | output | 4 | Base register index, taken from `issueWord` combinationally |
| baseVal | input | 32 | Base register value, valid with `issueValid` |
| busy | output | 1 | Instruction in flight |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 32 | Read byte address |
| memReqWide | output | 1 | 1 = 64-bit read, 0 = 32-bit read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data |
| wrEnA | output | 1 | First destination write enable |
| wrIdxA | output | 4 | First destination index |
| wrDataA | output | 32 | First destination data |
| wrEnB | output | 1 | Second destination write enable |
| wrIdxB | output | 4 | Second destination index |
| wrDataB | output | 32 | Second destination data |
| wbEn | output | 1 | Base writeback enable |
| wbIdx | output | 4 | Base register index |
| wbData | output | 32 | Updated base (offset address) |
| retire | output | 1 | Instruction completed |
| decodeErr | output | 1 | Illegal or hazardous word rejected |
| notMine | output | 1 | Word belongs to another decoder |

## Verification
Every rejection and every skipped instruction must show its strobe in the first cycle after the accepting edge. Writes land in the 4th cycle for aligned addresses and in the 6th for unaligned ones, plus any ready stall. Each scenario task counts falling edges from the accepting edge until a completion strobe appears, and compares that count with the expected latency. It then samples every write port and the memory-request log at that same falling edge, and samples `busy` and the strobes once more on the following edge. The bench memory answers exactly one cycle after each handshake, so the latency figures depend only on the design's own registers.

// File: rtl/dwload_pkg.sv
package dwload_pkg;
  localparam int WORD_W     = 32;
  localparam int IDX_W      = 4;
  localparam int PAIR_W     = 2 * WORD_W;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int ALIGN_BITS = $clog2(PAIR_W / 8);
  localparam logic [IDX_W-1:0] PC_IDX = '1;

  // control -> datapath strobes
  typedef struct packed {
    logic load;        // latch instruction context
    logic takeFirst;   // first response arrives
    logic takeSecond;  // second response arrives
    logic secondHalf;  // request targets address + one word
  } strobes_t;

  // datapath -> control decode summary
  typedef struct packed {
    logic malformed;
    logic foreign;
    logic hazard;
    logic writeBack;
    logic aligned;
  } decInfo_t;
endpackage

// File: rtl/dwload_dp.sv
module dwload_dp
  import dwload_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [WORD_W-1:0] issueWord,
  input  logic              wideFmt,
  input  logic              bigEndian,
  input  logic [WORD_W-1:0] baseVal,
  input  logic [PAIR_W-1:0] memRspData,
  output decInfo_t          info,
  output logic [WORD_W-1:0] reqAddr,
  output logic              reqWide,
  output logic [IDX_W-1:0]  idxA,
  output logic [IDX_W-1:0]  idxB,
  output logic [IDX_W-1:0]  idxBase,
  output logic [WORD_W-1:0] wordA,
  output logic [WORD_W-1:0] wordB,
  output logic [WORD_W-1:0] wbAddr
);
  logic [WORD_W-1:0] instrQ, baseQ, immExt, offAddr, accAddr;
  logic              wideQ, beQ, shapeOk;
  logic [IDX_W-1:0]  rt, rn, rt2;
  logic              pBit, uBit, wBit, wb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrQ <= '0;
      baseQ  <= '0;
      wideQ  <= 1'b0;
      beQ    <= 1'b0;
    end else if (stb.load) begin
      instrQ <= issueWord;
      baseQ  <= baseVal;
      wideQ  <= wideFmt;
      beQ    <= bigEndian;
    end
  end

  assign pBit = instrQ[24];
  assign uBit = instrQ[23];
  assign wBit = instrQ[21];
  assign rn   = instrQ[19:16];
  assign rt   = instrQ[15:12];

  always_comb begin
    if (wideQ) begin
      shapeOk = (instrQ[31:25] == 7'b1110100) && instrQ[22] && instrQ[20];
      rt2     = instrQ[11:8];
      immExt  = WORD_W'({instrQ[7:0], 2'b00});
      wb      = wBit;
      info.foreign = (rn == PC_IDX) || (!pBit && !wBit);
      info.hazard  = (rt == PC_IDX) || (rt2 == PC_IDX) || (rt == rt2)
                   || (wb && ((rn == rt) || (rn == rt2)));
    end else begin
      shapeOk = (instrQ[31:28] != 4'hF) && (instrQ[27:25] == 3'b000)
              && instrQ[22] && !instrQ[20] && (instrQ[7:4] == 4'b1101);
      rt2     = rt + IDX_W'(1);
      immExt  = WORD_W'({instrQ[11:8], instrQ[3:0]});
      wb      = !pBit || wBit;
      info.foreign = (rn == PC_IDX);
      info.hazard  = (!pBit && wBit) || rt[0] || (rt2 == PC_IDX)
                   || (wb && ((rn == rt) || (rn == rt2)));
    end
    info.malformed = !shapeOk;
    info.writeBack = wb;
  end

  assign offAddr      = uBit ? (baseQ + immExt) : (baseQ - immExt);
  assign accAddr      = pBit ? offAddr : baseQ;
  assign info.aligned = (accAddr[ALIGN_BITS-1:0] == '0);
  assign reqAddr      = stb.secondHalf ? (accAddr + WORD_W'(WORD_BYTES)) : accAddr;
  assign reqWide      = info.aligned && !stb.secondHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordA <= '0;
      wordB <= '0;
    end else begin
      if (stb.takeFirst) begin
        if (info.aligned) begin
          wordA <= beQ ? memRspData[PAIR_W-1:WORD_W] : memRspData[WORD_W-1:0];
          wordB <= beQ ? memRspData[WORD_W-1:0] : memRspData[PAIR_W-1:WORD_W];
        end else begin
          wordA <= memRspData[WORD_W-1:0];
        end
      end
      if (stb.takeSecond) wordB <= memRspData[WORD_W-1:0];
    end
  end

  assign idxA    = rt;
  assign idxB    = rt2;
  assign idxBase = rn;
  assign wbAddr  = offAddr;
endmodule

// File: rtl/dwload_ctrl.sv
module dwload_ctrl
  import dwload_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     issueValid,
  input  logic     condPass,
  input  decInfo_t info,
  input  logic     memReqReady,
  input  logic     memRspValid,
  output strobes_t stb,
  output logic     busy,
  output logic     memReqValid,
  output logic     wrEn,
  output logic     wbEn,
  output logic     retire,
  output logic     decodeErr,
  output logic     notMine
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_REQ1, ST_WAIT1, ST_REQ2, ST_WAIT2, ST_WRITE
  } state_t;

  state_t state, nextState;
  logic   condQ, reject, skip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      condQ <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.load) condQ <= condPass;
    end
  end

  assign reject = info.malformed || info.foreign || info.hazard;
  assign skip   = !reject && !condQ;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (issueValid) nextState = ST_EVAL;
      ST_EVAL:  nextState = (reject || !condQ) ? ST_IDLE : ST_REQ1;
      ST_REQ1:  if (memReqReady) nextState = ST_WAIT1;
      ST_WAIT1: if (memRspValid) nextState = info.aligned ? ST_WRITE : ST_REQ2;
      ST_REQ2:  if (memReqReady) nextState = ST_WAIT2;
      ST_WAIT2: if (memRspValid) nextState = ST_WRITE;
      ST_WRITE: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign stb.load       = (state == ST_IDLE) && issueValid;
  assign stb.takeFirst  = (state == ST_WAIT1) && memRspValid;
  assign stb.takeSecond = (state == ST_WAIT2) && memRspValid;
  assign stb.secondHalf = (state == ST_REQ2);

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_REQ1) || (state == ST_REQ2);
  assign wrEn        = (state == ST_WRITE);
  assign wbEn        = (state == ST_WRITE) && info.writeBack;
  assign retire      = (state == ST_WRITE) || ((state == ST_EVAL) && skip);
  assign decodeErr   = (state == ST_EVAL)
                     && (info.malformed || (!info.foreign && info.hazard));
  assign notMine     = (state == ST_EVAL) && !info.malformed && info.foreign;
endmodule

// File: rtl/dwload_unit.sv
module dwload_unit
  import dwload_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [WORD_W-1:0] issueWord,
  input  logic              wideFmt,
  input  logic              condPass,
  input  logic              bigEndian,
  output logic [IDX_W-1:0]  baseIdx,
  input  logic [WORD_W-1:0] baseVal,
  output logic              busy,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [WORD_W-1:0] memReqAddr,
  output logic              memReqWide,
  input  logic              memRspValid,
  input  logic [PAIR_W-1:0] memRspData,
  output logic              wrEnA,
  output logic [IDX_W-1:0]  wrIdxA,
  output logic [WORD_W-1:0] wrDataA,
  output logic              wrEnB,
  output logic [IDX_W-1:0]  wrIdxB,
  output logic [WORD_W-1:0] wrDataB,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [WORD_W-1:0] wbData,
  output logic              retire,
  output logic              decodeErr,
  output logic              notMine
);
  strobes_t stb;
  decInfo_t info;
  logic     wrEn;

  assign baseIdx = issueWord[19:16];

  dwload_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .condPass(condPass),
    .info(info), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .stb(stb), .busy(busy), .memReqValid(memReqValid), .wrEn(wrEn),
    .wbEn(wbEn), .retire(retire), .decodeErr(decodeErr), .notMine(notMine)
  );

  dwload_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .issueWord(issueWord),
    .wideFmt(wideFmt), .bigEndian(bigEndian), .baseVal(baseVal),
    .memRspData(memRspData), .info(info), .reqAddr(memReqAddr),
    .reqWide(memReqWide), .idxA(wrIdxA), .idxB(wrIdxB), .idxBase(wbIdx),
    .wordA(wrDataA), .wordB(wrDataB), .wbAddr(wbData)
  );

  assign wrEnA = wrEn;
  assign wrEnB = wrEn;
endmodule

// File: rtl/dwload_unit_chk.sv
module dwload_unit_chk
  import dwload_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [WORD_W-1:0] memReqAddr,
  input logic              memReqWide,
  input logic              wrEnA,
  input logic              wrEnB,
  input logic              wbEn,
  input logic              retire,
  input logic              decodeErr,
  input logic              notMine
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReqValid && !wrEnA && !wrEnB && !wbEn));

  assert_wide_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWide) |-> (memReqAddr[ALIGN_BITS-1:0] == '0));

  assert_pair_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEnA |-> (wrEnB && retire));

  assert_wb_in_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> wrEnA);

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    decodeErr |=> (!decodeErr && !busy));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    decodeErr |-> (!memReqValid && !wrEnA));

  assert_foreign_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    notMine |=> (!notMine && !busy));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({retire, decodeErr, notMine}));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWide)));
endmodule

bind dwload_unit dwload_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memReqWide(memReqWide),
  .wrEnA(wrEnA), .wrEnB(wrEnB), .wbEn(wbEn), .retire(retire),
  .decodeErr(decodeErr), .notMine(notMine)
);

// File: tb/dwload_unit_tb_top.sv
module dwload_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] issueWord = '0;
  logic        wideFmt = 1'b0, condPass = 1'b0, bigEndian = 1'b0;
  logic [3:0]  baseIdx;
  logic [31:0] baseVal = '0;
  logic        busy, memReqValid, memReqWide;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        wrEnA, wrEnB, wbEn, retire, decodeErr, notMine;
  logic [3:0]  wrIdxA, wrIdxB, wbIdx;
  logic [31:0] wrDataA, wrDataB, wbData;

  int errors = 0;
  int checks = 0;

  // bench memory state
  int          stallLeft = 0;
  int          reqCnt = 0;
  logic [31:0] reqAddrLog [2];
  logic        reqWideLog [2];
  logic        pending = 1'b0;
  logic [31:0] pendAddr = '0;
  logic        pendWide = 1'b0;

  // captured result
  int          gotKind, gotLat;
  logic        cEnA, cEnB, cWb;
  logic [3:0]  cIdxA, cIdxB, cWbIdx;
  logic [31:0] cDataA, cDataB, cWbData;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwload_unit dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueWord(issueWord),
    .wideFmt(wideFmt), .condPass(condPass), .bigEndian(bigEndian),
    .baseIdx(baseIdx), .baseVal(baseVal), .busy(busy),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqWide(memReqWide),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .wrEnA(wrEnA), .wrIdxA(wrIdxA), .wrDataA(wrDataA),
    .wrEnB(wrEnB), .wrIdxB(wrIdxB), .wrDataB(wrDataB),
    .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData),
    .retire(retire), .decodeErr(decodeErr), .notMine(notMine)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  function automatic logic [31:0] fixEnc(input logic [3:0] c, input logic p, u, w,
                                         input logic [3:0] rn, rt, input logic [7:0] imm);
    return {c, 3'b000, p, u, 1'b1, w, 1'b0, rn, rt, imm[7:4], 4'b1101, imm[3:0]};
  endfunction

  function automatic logic [31:0] wideEnc(input logic p, u, w,
                                          input logic [3:0] rn, rt, rt2, input logic [7:0] imm);
    return {7'b1110100, p, u, 1'b1, w, 1'b1, rn, rt, rt2, imm};
  endfunction

  // memory responder: answers one cycle after each handshake
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = pending;
      if (pending)
        memRspData = pendWide ? {memWord(pendAddr + 32'd4), memWord(pendAddr)}
                              : {32'h0, memWord(pendAddr)};
      if (memReqValid && stallLeft > 0) begin
        memReqReady = 1'b0;
        stallLeft--;
      end else begin
        memReqReady = 1'b1;
      end
      pending = memReqValid && memReqReady;
      if (pending) begin
        pendAddr = memReqAddr;
        pendWide = memReqWide;
        if (reqCnt < 2) begin
          reqAddrLog[reqCnt] = memReqAddr;
          reqWideLog[reqCnt] = memReqWide;
        end
        reqCnt++;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // offer one instruction, wait for a completion strobe, capture the ports
  task automatic issue(input logic [31:0] word, input logic wide, input logic [31:0] base,
                       input logic be, input logic cond, input int stall);
    @(negedge clk);
    reqCnt     = 0;
    stallLeft  = stall;
    issueWord  = word;
    wideFmt    = wide;
    baseVal    = base;
    bigEndian  = be;
    condPass   = cond;
    issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    gotLat  = 1;
    gotKind = 3;
    for (int i = 0; i < 60; i++) begin
      if (retire || decodeErr || notMine) begin
        gotKind = retire ? 0 : (decodeErr ? 1 : 2);
        break;
      end
      @(negedge clk);
      gotLat++;
    end
    cEnA = wrEnA;  cEnB = wrEnB;  cWb = wbEn;
    cIdxA = wrIdxA; cIdxB = wrIdxB; cWbIdx = wbIdx;
    cDataA = wrDataA; cDataB = wrDataB; cWbData = wbData;
  endtask

  task automatic runLegal(input string tag, input logic [31:0] word, input logic wide,
                          input logic [31:0] base, input logic be, input logic [31:0] acc,
                          input logic [3:0] t, t2, input logic wbExp, input logic [3:0] rn,
                          input logic [31:0] wbAddr, input int stall);
    logic        al;
    logic [31:0] lo, hi, expA, expB;
    al = (acc[2:0] == 3'b000);
    lo = memWord(acc);
    hi = memWord(acc + 32'd4);
    expA = (al && be) ? hi : lo;
    expB = (al && be) ? lo : hi;
    issue(word, wide, base, be, cond1(), stall);
    chk(tag, "completion kind", 64'(gotKind), 64'd0);
    chk({tag, " R11"}, "write latency", 64'(gotLat), 64'((al ? 4 : 6) + stall));
    chk(tag, "write enables", {62'd0, cEnA, cEnB}, 64'd3);
    chk(tag, "first index", 64'(cIdxA), 64'(t));
    chk(tag, "second index", 64'(cIdxB), 64'(t2));
    chk(tag, "first data", 64'(cDataA), 64'(expA));
    chk(tag, "second data", 64'(cDataB), 64'(expB));
    chk({tag, " R6"}, "writeback enable", 64'(cWb), 64'(wbExp));
    if (wbExp) begin
      chk({tag, " R6"}, "writeback index", 64'(cWbIdx), 64'(rn));
      chk({tag, " R6"}, "writeback data", 64'(cWbData), 64'(wbAddr));
    end
    chk(tag, "read count", 64'(reqCnt), al ? 64'd1 : 64'd2);
    chk(tag, "first read address", 64'(reqAddrLog[0]), 64'(acc));
    chk(tag, "first read size", 64'(reqWideLog[0]), 64'(al));
    if (!al) begin
      chk({tag, " R5"}, "second read address", 64'(reqAddrLog[1]), 64'(acc + 32'd4));
      chk({tag, " R5"}, "second read size", 64'(reqWideLog[1]), 64'd0);
    end
    @(negedge clk);
    chk({tag, " R10"}, "busy after write", 64'(busy), 64'd0);
  endtask

  function automatic logic cond1();
    return 1'b1;
  endfunction

  // expKind: 0 retire, 1 decodeErr, 2 notMine
  task automatic runQuick(input string tag, input logic [31:0] word, input logic wide,
                          input logic cond, input int expKind);
    issue(word, wide, 32'h0000_8000, 1'b0, cond, 0);
    chk(tag, "strobe kind", 64'(gotKind), 64'(expKind));
    chk(tag, "strobe latency", 64'(gotLat), 64'd1);
    chk(tag, "no register write", {61'd0, cEnA, cEnB, cWb}, 64'd0);
    @(negedge clk);
    chk(tag, "strobe gone and idle", {60'd0, busy, retire, decodeErr, notMine}, 64'd0);
    chk(tag, "no memory read", 64'(reqCnt), 64'd0);
  endtask

  task automatic testReset();
    chk("R1", "idle outputs",
        {57'd0, busy, memReqValid, wrEnA, wrEnB, wbEn, retire, decodeErr | notMine}, 64'd0);
  endtask

  task automatic testFixedAligned();
    runLegal("R2 R4 fixed offset little", fixEnc(4'hE, 1, 1, 0, 4'd2, 4'd4, 8'h18), 1'b0,
             32'h1000, 1'b0, 32'h1018, 4'd4, 4'd5, 1'b0, 4'd2, 32'h0, 0);
  endtask

  task automatic testFixedPreBig();
    runLegal("R4 R6 fixed pre big", fixEnc(4'hE, 1, 1, 1, 4'd1, 4'd6, 8'h0C), 1'b0,
             32'h2004, 1'b1, 32'h2010, 4'd6, 4'd7, 1'b1, 4'd1, 32'h2010, 0);
  endtask

  task automatic testFixedPostUnaligned();
    runLegal("R2 R5 fixed post sub", fixEnc(4'hE, 0, 0, 0, 4'd3, 4'd8, 8'h20), 1'b0,
             32'h3004, 1'b0, 32'h3004, 4'd8, 4'd9, 1'b1, 4'd3, 32'h2FE4, 0);
  endtask

  task automatic testWideUnalignedBig();
    runLegal("R3 R5 wide offset big", wideEnc(1, 0, 0, 4'd7, 4'd5, 4'd2, 8'h41), 1'b1,
             32'h4100, 1'b1, 32'h3FFC, 4'd5, 4'd2, 1'b0, 4'd7, 32'h0, 0);
  endtask

  task automatic testWidePostBig();
    runLegal("R3 R4 R6 wide post big", wideEnc(0, 1, 1, 4'd9, 4'd10, 4'd11, 8'h03), 1'b1,
             32'h5000, 1'b1, 32'h5000, 4'd10, 4'd11, 1'b1, 4'd9, 32'h500C, 0);
  endtask

  task automatic testStall();
    runLegal("R10 R11 stalled ready", fixEnc(4'hE, 1, 1, 0, 4'd2, 4'd4, 8'h18), 1'b0,
             32'h1000, 1'b0, 32'h1018, 4'd4, 4'd5, 1'b0, 4'd2, 32'h0, 3);
  endtask

  task automatic testCondFail();
    runQuick("R9 condition false", fixEnc(4'h0, 1, 1, 0, 4'd2, 4'd4, 8'h18), 1'b0, 1'b0, 0);
  endtask

  task automatic testHazards();
    runQuick("R7 odd first dest", fixEnc(4'hE, 1, 1, 0, 4'd2, 4'd5, 8'h0), 1'b0, 1'b1, 1);
    runQuick("R7 second dest 15", fixEnc(4'hE, 1, 1, 0, 4'd2, 4'd14, 8'h0), 1'b0, 1'b1, 1);
    runQuick("R7 post with W", fixEnc(4'hE, 0, 1, 1, 4'd2, 4'd4, 8'h0), 1'b0, 1'b1, 1);
    runQuick("R7 fixed wb base clash", fixEnc(4'hE, 1, 1, 1, 4'd5, 4'd4, 8'h0), 1'b0, 1'b1, 1);
    runQuick("R7 wide equal dests", wideEnc(1, 1, 0, 4'd2, 4'd3, 4'd3, 8'h0), 1'b1, 1'b1, 1);
    runQuick("R7 wide wb base clash", wideEnc(1, 1, 1, 4'd3, 4'd4, 4'd3, 8'h0), 1'b1, 1'b1, 1);
    runQuick("R7 wide dest 15", wideEnc(1, 1, 0, 4'd2, 4'd15, 4'd3, 8'h0), 1'b1, 1'b1, 1);
    runQuick("R7 hazard with cond false", fixEnc(4'hE, 1, 1, 0, 4'd2, 4'd5, 8'h0), 1'b0, 1'b0, 1);
  endtask

  task automatic testMalformed();
    runQuick("R7 predicate all ones", fixEnc(4'hF, 1, 1, 0, 4'd2, 4'd4, 8'h0), 1'b0, 1'b1, 1);
    runQuick("R7 fixed word in wide mode", fixEnc(4'hE, 1, 1, 0, 4'd2, 4'd4, 8'h0), 1'b1, 1'b1, 1);
  endtask

  task automatic testForeign();
    runQuick("R8 base field 15", fixEnc(4'hE, 1, 1, 0, 4'd15, 4'd4, 8'h0), 1'b0, 1'b1, 2);
    runQuick("R8 wide P0 W0", wideEnc(0, 1, 0, 4'd2, 4'd4, 4'd6, 8'h0), 1'b1, 1'b1, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testFixedAligned();
    testFixedPreBig();
    testFixedPostUnaligned();
    testWideUnalignedBig();
    testWidePostBig();
    testStall();
    testCondFail();
    testHazards();
    testMalformed();
    testForeign();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule